// File: doc/BRIEF.md
# Polled Byte Transfer Controller

This block is the controller side of a polled, one-byte-at-a-time device interface. A host reaches it through a small register bus with a two-bit address, a write enable, write data and combinational read data. Through four registers the host sees a status word, programs a command word, collects a received byte and stages a byte to send. A host-owned command-ready flag and a controller-owned busy flag pace each transfer.

The host first polls status until busy is clear. It then writes the outgoing byte and the command, and sets command-ready. The controller takes the request and raises busy. It then either presents the staged byte to the device until the device accepts it, or waits for the device to deliver a byte, which it stores in the data-in register. Completion is shown to the host in a fixed three-step order: command-ready falls, then the error flag is written with the outcome, then busy falls. The command word also carries a device mode field, which drives a mode output to the device.

Top module: `pio_byte_ctrl`

## Requirements
- R1: After reset, all four registers read as zero, `dev_tx_valid` is 0 and `dev_mode` is 0.
- R2: Read data depends on `host_addr`. Address 0 returns status with busy in bit 0, command-ready in bit 1, error in bit 2 and zeros above. Address 1 returns the command word. Address 2 returns data-in. Address 3 returns data-out.
- R3: A host write to address 0 with bit 1 set sets command-ready at the next clock edge, but only while busy and command-ready are both clear. Bits 0 and 2 of status cannot be written by the host.
- R4: On the clock edge after command-ready is seen set while the controller is idle, busy becomes 1.
- R5: A host write to the command register (address 1) or to data-out (address 3) is ignored while busy or command-ready is set.
- R6: A command whose low two bits are 01 (write) holds `dev_tx_valid` high, with `dev_tx_data` equal to data-out, from the cycle in which busy first reads 1 until a cycle in which `dev_tx_accept` is high.
- R7: A command whose low two bits are 10 (read) waits for `dev_rx_valid`. The value on `dev_rx_data` in that cycle is stored in data-in.
- R8: The clock edge that ends an operation starts a fixed sequence. One edge later, command-ready is cleared. The next edge writes the error flag: 0 on success, 1 on failure. The edge after that clears busy. The error flag never changes while busy is clear.
- R9: If `dev_err` is high in any cycle of an executing operation, the operation ends in that cycle and the error flag is set.
- R10: A command whose low two bits are 00 or 11 ends in its first executing cycle, with the error flag set.
- R11: Bits 5:2 of the command register drive `dev_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_addr | input | 2 | Register select |
| host_we | input | 1 | Register write enable |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data (combinational from address) |
| dev_tx_data | output | 8 | Byte offered to the device |
| dev_tx_valid | output | 1 | Outgoing byte is valid |
| dev_tx_accept | input | 1 | Device takes the outgoing byte this cycle |
| dev_rx_data | input | 8 | Byte from the device |
| dev_rx_valid | input | 1 | Incoming byte is valid this cycle |
| dev_err | input | 1 | Device reports a failure |
| dev_mode | output | 4 | Device mode field from the command register |

## Verification
The bench builds the block with its default parameters: an 8-bit data path and a 4-bit mode field starting at command bit 2. At these values the command codes 00 and 11, the full mode range and byte patterns with both high and low bits set can all be driven directly. The bench exercises device stalls of several cycles, a device error during a write, and register writes during a busy operation. In each case the status sequence is compared cycle by cycle against a behavioural model.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned ADDR_W    = 2;
  localparam logic [1:0]  A_STATUS  = 2'd0;
  localparam logic [1:0]  A_CMD     = 2'd1;
  localparam logic [1:0]  A_DIN     = 2'd2;
  localparam logic [1:0]  A_DOUT    = 2'd3;

  localparam int unsigned ST_BUSY   = 0;
  localparam int unsigned ST_CRDY   = 1;
  localparam int unsigned ST_ERR    = 2;

  localparam logic [1:0]  OP_WRITE  = 2'b01;
  localparam logic [1:0]  OP_READ   = 2'b10;

  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_EXEC     = 3'd1,
    PH_CLR_CRDY = 3'd2,
    PH_SET_ERR  = 3'd3,
    PH_CLR_BUSY = 3'd4
  } phase_e;
endpackage

// File: rtl/pio_rst_sync.sv
module pio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pio_regfile.sv
module pio_regfile
  import pio_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_we,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              busy,
  input  logic              err,
  input  logic              crdy_clr,
  input  logic              rx_load,
  input  logic [DATA_W-1:0] rx_data,
  output logic              cmd_rdy,
  output logic [DATA_W-1:0] cmd_word,
  output logic [DATA_W-1:0] dout_word
);
  logic [DATA_W-1:0] din_q, din_d;
  logic [DATA_W-1:0] cmd_q, cmd_d;
  logic [DATA_W-1:0] dout_q, dout_d;
  logic              crdy_q, crdy_d;
  logic              locked;
  logic              wr_status, wr_cmd, wr_dout;
  logic              din_en, cmd_en, dout_en, crdy_en;

  assign locked    = busy | crdy_q;
  assign wr_status = host_we && (host_addr == A_STATUS);
  assign wr_cmd    = host_we && (host_addr == A_CMD);
  assign wr_dout   = host_we && (host_addr == A_DOUT);

  always_comb begin
    cmd_en  = wr_cmd && !locked;
    dout_en = wr_dout && !locked;
    din_en  = rx_load;
    crdy_en = crdy_clr || (wr_status && host_wdata[ST_CRDY] && !locked);
    cmd_d   = host_wdata;
    dout_d  = host_wdata;
    din_d   = rx_data;
    crdy_d  = !crdy_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      dout_q <= '0;
      din_q  <= '0;
      crdy_q <= 1'b0;
    end else begin
      if (cmd_en)  cmd_q  <= cmd_d;
      if (dout_en) dout_q <= dout_d;
      if (din_en)  din_q  <= din_d;
      if (crdy_en) crdy_q <= crdy_d;
    end
  end

  always_comb begin
    host_rdata = '0;
    unique case (host_addr)
      A_STATUS: begin
        host_rdata[ST_BUSY] = busy;
        host_rdata[ST_CRDY] = crdy_q;
        host_rdata[ST_ERR]  = err;
      end
      A_CMD:   host_rdata = cmd_q;
      A_DIN:   host_rdata = din_q;
      default: host_rdata = dout_q;
    endcase
  end

  assign cmd_rdy   = crdy_q;
  assign cmd_word  = cmd_q;
  assign dout_word = dout_q;
endmodule

// File: rtl/pio_hs_fsm.sv
module pio_hs_fsm
  import pio_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_rdy,
  input  logic [DATA_W-1:0] cmd_word,
  input  logic              dev_tx_accept,
  input  logic              dev_rx_valid,
  input  logic              dev_err,
  output logic              busy,
  output logic              err,
  output logic              crdy_clr,
  output logic              rx_load,
  output logic              tx_valid
);
  phase_e ph_q, ph_d;
  logic   busy_q, busy_d;
  logic   err_q, err_d;
  logic   errp_q, errp_d;
  logic   is_wr, is_rd, is_bad, finish;

  assign is_wr  = (cmd_word[1:0] == OP_WRITE);
  assign is_rd  = (cmd_word[1:0] == OP_READ);
  assign is_bad = !(is_wr || is_rd);
  assign finish = is_bad || dev_err || (is_wr && dev_tx_accept) || (is_rd && dev_rx_valid);

  always_comb begin
    ph_d     = ph_q;
    busy_d   = busy_q;
    err_d    = err_q;
    errp_d   = errp_q;
    crdy_clr = 1'b0;
    rx_load  = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (cmd_rdy) begin
          ph_d   = PH_EXEC;
          busy_d = 1'b1;
          errp_d = 1'b0;
        end
      end
      PH_EXEC: begin
        rx_load = is_rd && dev_rx_valid;
        if (finish) begin
          ph_d   = PH_CLR_CRDY;
          errp_d = is_bad || dev_err;
        end
      end
      PH_CLR_CRDY: begin
        crdy_clr = 1'b1;
        ph_d     = PH_SET_ERR;
      end
      PH_SET_ERR: begin
        err_d = errp_q;
        ph_d  = PH_CLR_BUSY;
      end
      PH_CLR_BUSY: begin
        busy_d = 1'b0;
        ph_d   = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      errp_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      busy_q <= busy_d;
      err_q  <= err_d;
      errp_q <= errp_d;
    end
  end

  assign busy     = busy_q;
  assign err      = err_q;
  assign tx_valid = (ph_q == PH_EXEC) && is_wr;
endmodule

// File: rtl/pio_byte_ctrl.sv
module pio_byte_ctrl
  import pio_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MODE_LSB = 2,
  parameter int unsigned MODE_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_addr,
  input  logic              host_we,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic [DATA_W-1:0] dev_tx_data,
  output logic              dev_tx_valid,
  input  logic              dev_tx_accept,
  input  logic [DATA_W-1:0] dev_rx_data,
  input  logic              dev_rx_valid,
  input  logic              dev_err,
  output logic [MODE_W-1:0] dev_mode
);
  localparam int unsigned MODE_MSB = MODE_LSB + MODE_W - 1;

  logic              rst_n_int;
  logic              st_busy, st_err, st_crdy;
  logic              crdy_clr, rx_load;
  logic [DATA_W-1:0] cmd_word, dout_word;

  pio_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pio_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .host_addr  (host_addr),
    .host_we    (host_we),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .busy       (st_busy),
    .err        (st_err),
    .crdy_clr   (crdy_clr),
    .rx_load    (rx_load),
    .rx_data    (dev_rx_data),
    .cmd_rdy    (st_crdy),
    .cmd_word   (cmd_word),
    .dout_word  (dout_word)
  );

  pio_hs_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .cmd_rdy       (st_crdy),
    .cmd_word      (cmd_word),
    .dev_tx_accept (dev_tx_accept),
    .dev_rx_valid  (dev_rx_valid),
    .dev_err       (dev_err),
    .busy          (st_busy),
    .err           (st_err),
    .crdy_clr      (crdy_clr),
    .rx_load       (rx_load),
    .tx_valid      (dev_tx_valid)
  );

  assign dev_tx_data = dout_word;
  assign dev_mode    = cmd_word[MODE_MSB:MODE_LSB];
endmodule

// File: rtl/pio_byte_ctrl_chk.sv
module pio_byte_ctrl_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              crdy,
  input logic              err,
  input logic              tx_valid,
  input logic [DATA_W-1:0] tx_data,
  input logic [MODE_W-1:0] mode
);
  AST_BUSY_FOLLOWS_CRDY: assert property (@(posedge clk) disable iff (!rst_n)
    (crdy && !busy) |=> busy); // R4
  AST_TXV_INSIDE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (busy && crdy)); // R6
  AST_TXDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && $past(tx_valid)) |-> $stable(tx_data)); // R6
  AST_MODE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mode)); // R5
  AST_CRDY_DROPS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(crdy) |-> busy); // R8
  AST_BUSY_DROPS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!crdy && $stable(err))); // R8
  AST_ERR_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> $stable(err)); // R8
endmodule

bind pio_byte_ctrl pio_byte_ctrl_chk #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (st_busy),
  .crdy     (st_crdy),
  .err      (st_err),
  .tx_valid (dev_tx_valid),
  .tx_data  (dev_tx_data),
  .mode     (dev_mode)
);

// File: tb/pio_byte_ctrl_tb.sv
module pio_byte_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic       host_we = 1'b0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic [7:0] dev_tx_data;
  logic       dev_tx_valid;
  logic       dev_tx_accept = 1'b0;
  logic [7:0] dev_rx_data = 8'd0;
  logic       dev_rx_valid = 1'b0;
  logic       dev_err = 1'b0;
  logic [3:0] dev_mode;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // behavioural reference state
  bit       m_crdy, m_busy, m_err, m_errp;
  bit [7:0] m_cmd, m_dout, m_din;
  int       m_phase;

  always #4 clk = ~clk;

  pio_byte_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .dev_tx_data(dev_tx_data),
    .dev_tx_valid(dev_tx_valid), .dev_tx_accept(dev_tx_accept),
    .dev_rx_data(dev_rx_data), .dev_rx_valid(dev_rx_valid), .dev_err(dev_err),
    .dev_mode(dev_mode)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cycles, act, exp);
    end
  endtask

  function automatic bit [7:0] m_rdata(bit [1:0] a);
    case (a)
      2'd0: return {5'd0, m_err, m_crdy, m_busy};
      2'd1: return m_cmd;
      2'd2: return m_din;
      default: return m_dout;
    endcase
  endfunction

  // reference model step and per-cycle compare
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_crdy = 0; m_busy = 0; m_err = 0; m_errp = 0;
      m_cmd = 0; m_dout = 0; m_din = 0; m_phase = 0;
    end else begin
      bit lk, wr, rd, bad, nc, nb;
      bit [7:0] ncmd, ndout;
      lk = m_busy || m_crdy;
      nc = m_crdy; nb = m_busy; ncmd = m_cmd; ndout = m_dout;
      if (host_we && host_addr == 2'd0 && host_wdata[1] && !lk) nc = 1;
      if (host_we && host_addr == 2'd1 && !lk) ncmd = host_wdata;
      if (host_we && host_addr == 2'd3 && !lk) ndout = host_wdata;
      wr = (m_cmd[1:0] == 2'b01);
      rd = (m_cmd[1:0] == 2'b10);
      bad = !(wr || rd);
      case (m_phase)
        0: if (m_crdy) begin nb = 1; m_errp = 0; m_phase = 1; end
        1: begin
          if (rd && dev_rx_valid) m_din = dev_rx_data;
          if (bad || dev_err || (wr && dev_tx_accept) || (rd && dev_rx_valid)) begin
            m_errp = bad || dev_err;
            m_phase = 2;
          end
        end
        2: begin nc = 0; m_phase = 3; end
        3: begin m_err = m_errp; m_phase = 4; end
        default: begin nb = 0; m_phase = 0; end
      endcase
      m_crdy = nc; m_busy = nb; m_cmd = ncmd; m_dout = ndout;
    end
    #2;
    if (rst_n && !finished) begin
      check("R2/R8 read data", host_rdata, m_rdata(host_addr));
      check("R6 tx_valid", dev_tx_valid, (m_phase == 1) && (m_cmd[1:0] == 2'b01));
      if (dev_tx_valid) check("R6 tx_data", dev_tx_data, m_dout);
      check("R11 mode", dev_mode, m_cmd[5:2]);
    end
  end

  task automatic hwrite(bit [1:0] a, bit [7:0] d);
    @(negedge clk);
    host_addr = a; host_we = 1'b1; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0; host_addr = 2'd0;
  endtask

  task automatic peek(string req, bit [1:0] a, bit [7:0] exp);
    @(negedge clk);
    host_addr = a;
    #1;
    check(req, host_rdata, exp);
    host_addr = 2'd0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    host_addr = 2'd0;
    #1;
    while (host_rdata[1:0] != 2'b00) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic start(bit [7:0] cmd);
    hwrite(2'd1, cmd);
    hwrite(2'd0, 8'h02);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int a = 0; a < 4; a++) peek("R1 reset value", a[1:0], 8'h00);
    check("R1 tx_valid reset", dev_tx_valid, 0);
    check("R1 mode reset", dev_mode, 0);

    // R3: status bits 0 and 2 are not host-writable
    hwrite(2'd0, 8'h05);
    peek("R3 status not writable", 2'd0, 8'h00);

    // R6 write with a stalled device, mode 3
    hwrite(2'd3, 8'hA5);
    start(8'h0D);
    @(negedge clk); #1;
    check("R4 busy set", host_rdata, 8'h03);
    hwrite(2'd3, 8'hFF);            // R5 ignored while busy
    hwrite(2'd1, 8'h02);            // R5 ignored while busy
    repeat (2) @(negedge clk);
    dev_tx_accept = 1'b1;
    @(negedge clk);
    dev_tx_accept = 1'b0;
    #1;
    check("R8 crdy still set after accept edge", host_rdata, 8'h03);
    @(negedge clk); #1;
    check("R8 crdy cleared first", host_rdata, 8'h01);
    @(negedge clk); #1;
    check("R8 err written, busy held", host_rdata, 8'h01);
    @(negedge clk); #1;
    check("R8 busy cleared last", host_rdata, 8'h00);
    peek("R5 data-out kept", 2'd3, 8'hA5);
    peek("R5 command kept", 2'd1, 8'h0D);
    check("R11 mode field", dev_mode, 4'h3);

    // R7 read with a wait, mode 10
    start(8'h2A);
    repeat (3) @(negedge clk);
    dev_rx_data = 8'h3C; dev_rx_valid = 1'b1;
    @(negedge clk);
    dev_rx_valid = 1'b0; dev_rx_data = 8'hEE;
    wait_idle();
    peek("R7 data-in captured", 2'd2, 8'h3C);
    peek("R7 no error", 2'd0, 8'h00);

    // R9 device error during write
    start(8'h01);
    repeat (2) @(negedge clk);
    dev_err = 1'b1;
    @(negedge clk);
    dev_err = 1'b0;
    wait_idle();
    peek("R9 error set", 2'd0, 8'h04);

    // R8 success clears error
    hwrite(2'd3, 8'h5A);
    start(8'h01);
    @(negedge clk);
    dev_tx_accept = 1'b1;
    @(negedge clk);
    dev_tx_accept = 1'b0;
    wait_idle();
    peek("R8 error cleared on success", 2'd0, 8'h00);

    // R10 invalid codes 00 and 11
    start(8'h00);
    wait_idle();
    peek("R10 code 00 error", 2'd0, 8'h04);
    start(8'h01);
    dev_tx_accept = 1'b1;
    wait_idle();
    dev_tx_accept = 1'b0;
    start(8'h03);
    wait_idle();
    peek("R10 code 11 error", 2'd0, 8'h04);
    peek("R7 data-in untouched by write", 2'd2, 8'h3C);

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule